// File: doc/BRIEF.md
# Four-Channel DMA Arming Register Bank

This block holds the programming registers of four DMA channels and turns a write of a channel's control word into an armed transfer descriptor. Software writes through a simple register port. The port takes halfword or single-byte writes, selected by two byte lanes. Each channel owns a 12-byte window: a 32-bit source pointer, a 32-bit destination pointer, a 16-bit unit count and a 16-bit control word.

A write to the upper byte of a control word is evaluated as a command. If the enable bit is set and the channel is idle, the block captures a working descriptor. The descriptor holds masked addresses, an expanded count and the decoded mode fields. The block applies the per-channel special cases: the short count on the lower channels, the audio-feed mode on the middle channels and the large-EEPROM detection on the top channel. An immediate-start request leaves the block as a one-cycle pulse tagged with the channel index. A separate transfer engine consumes the descriptors and the pulse.

Top module: `dma_arm_bank`

## Requirements
- R1: After reset every control word, armed flag, descriptor field, start pulse and the EEPROM flag read zero.
- R2: Channel c occupies offsets 0xB0+12c onward: source low/high halfwords at +0/+2, destination at +4/+6, count at +8, control at +10. Byte lane 0 writes bits 7:0 and lane 1 writes bits 15:8. A control write carrying only lane 1 is merged with the stored low byte before evaluation.
- R3: A control write that carries lane 1 with bit 15 set on an idle channel arms it on the next cycle. The descriptor captures source and destination masked to 28 bits, irq = bit 14, timing = bits 13:12 (00 immediate, 11 special), wide = bit 10, repeat = bit 9, source direction = bits 8:7 and destination direction = bits 6:5.
- R4: An enabling control write to an already armed channel stores the new control word and leaves every descriptor field unchanged. It raises no start pulse.
- R5: A control write with bit 15 clear stores the word, clears the armed flag and sets the audio selection to 00.
- R6: Outside audio-feed mode, channels 0 to 2 use the low 14 count bits and channel 3 uses all 16. A resulting count of zero becomes 0x4000 on channels 0 to 2 and 0x10000 on channel 3.
- R7: Channels 1 and 2 armed with special timing enter audio-feed mode. The count becomes 4, wide becomes 1 and the destination direction becomes 10 (fixed), regardless of the count register and bits 6:5. The audio selection is 10 (B) when the masked destination equals 0x40000A4 and 01 (A) otherwise. All other arms give 00.
- R8: Arming channel 3 with destination bits 31:24 equal to 0x0D and count bits 4:0 equal to 17 sets a sticky EEPROM flag. Only reset clears it.
- R9: Arming with immediate timing raises start_pulse for exactly the one cycle after the write, with start_chan naming the channel. On simultaneous requests the lowest channel number wins.
- R10: A control write carrying lane 0 only stores the low byte and never arms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the halfword written |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte lane enables |
| ctrl_word | output | 64 | Stored control word per channel |
| armed | output | 4 | Armed flag per channel |
| desc_src | output | 112 | Latched 28-bit source per channel |
| desc_dst | output | 112 | Latched 28-bit destination per channel |
| desc_cnt | output | 68 | Expanded 17-bit unit count per channel |
| desc_timing | output | 8 | Start timing code per channel |
| desc_irq | output | 4 | Interrupt request bit per channel |
| desc_wide | output | 4 | 32-bit unit flag per channel |
| desc_repeat | output | 4 | Repeat flag per channel |
| desc_src_dir | output | 8 | Source direction per channel |
| desc_dst_dir | output | 8 | Destination direction per channel |
| desc_snd | output | 8 | Audio selection per channel (00 none, 01 A, 10 B) |
| start_pulse | output | 1 | One-cycle immediate start request |
| start_chan | output | 2 | Channel of the start request |
| eeprom_large | output | 1 | Sticky large-EEPROM flag |

## Verification
The assertions assume that write addresses are halfword aligned and that wr_en stays low while reset is held. Under those conditions the decode hits at most one slot, and armed state can only rise from a command write. The stimulus meets both: it issues writes only at even offsets inside the channel windows, and it keeps the write strobe idle until reset has been released. The main sweep crosses every channel with every timing code, several count values and both audio destinations. Every arm in that sweep is followed by a disabling write, so each arm starts from the idle state.

// File: rtl/dma_arm_pkg.sv
`timescale 1ns/1ps
package dma_arm_pkg;
  localparam int unsigned ADDR_KEEP_W = 28;
  localparam int unsigned CNT_W       = 17;
  localparam int unsigned SHORT_CNT_W = 14;
  localparam int unsigned FIFO_WORDS  = 4;

  localparam logic [ADDR_KEEP_W-1:0] FIFO_B_ADDR = 28'h40000A4;
  localparam logic [7:0]             EE_DST_TAG  = 8'h0D;
  localparam logic [4:0]             EE_CNT_TAG  = 5'd17;
  localparam logic [1:0]             DIR_FIXED   = 2'b10;

  typedef enum logic [1:0] {
    TM_IMM     = 2'b00,
    TM_EVT_A   = 2'b01,
    TM_EVT_B   = 2'b10,
    TM_SPECIAL = 2'b11
  } timing_e;

  typedef enum logic [1:0] {
    SND_NONE = 2'b00,
    SND_A    = 2'b01,
    SND_B    = 2'b10
  } snd_e;

  typedef struct packed {
    logic [ADDR_KEEP_W-1:0] src;
    logic [ADDR_KEEP_W-1:0] dst;
    logic [CNT_W-1:0]       cnt;
    logic                   wide;
    logic                   repeat_en;
    logic                   irq;
    logic [1:0]             src_dir;
    logic [1:0]             dst_dir;
    timing_e                timing;
    snd_e                   snd;
  } desc_t;
endpackage

// File: rtl/dma_arm_regs.sv
`timescale 1ns/1ps
module dma_arm_regs #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 176,
  parameter int unsigned STRIDE = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [15:0]           wr_data,
  input  logic [1:0]            wr_be,
  output logic [N_CH-1:0][31:0] src_q,
  output logic [N_CH-1:0][31:0] dst_q,
  output logic [N_CH-1:0][15:0] cnt_q,
  output logic [N_CH-1:0][15:0] ctrl_q,
  output logic [N_CH-1:0]       trig_vec,
  output logic [15:0]           trig_val
);
  localparam int unsigned HW_N   = STRIDE / 2;
  localparam int unsigned SLOT_W = $clog2(HW_N);
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;

  localparam logic [SLOT_W-1:0] SL_SRC_LO = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SL_SRC_HI = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SL_DST_LO = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SL_DST_HI = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] SL_CNT    = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] SL_CTRL   = SLOT_W'(5);

  logic              hit;
  logic [CH_W-1:0]   hit_ch;
  logic [SLOT_W-1:0] hit_slot;
  logic [ADDR_W:0]   rel;

  // window decode: one channel window per STRIDE bytes
  always_comb begin
    hit      = 1'b0;
    hit_ch   = '0;
    hit_slot = '0;
    rel      = '0;
    for (int c = 0; c < N_CH; c++) begin
      rel = {1'b0, wr_addr} - (ADDR_W+1)'(BASE + c * STRIDE);
      if (rel < (ADDR_W+1)'(STRIDE)) begin
        hit      = 1'b1;
        hit_ch   = CH_W'(c);
        hit_slot = SLOT_W'(rel >> 1);
      end
    end
  end

  logic [15:0] hw_q [N_CH][HW_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < N_CH; c++)
        for (int s = 0; s < HW_N; s++)
          hw_q[c][s] <= '0;
    end else if (wr_en && hit) begin
      if (wr_be[0]) hw_q[hit_ch][hit_slot][7:0]  <= wr_data[7:0];
      if (wr_be[1]) hw_q[hit_ch][hit_slot][15:8] <= wr_data[15:8];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_view
    assign src_q[c]    = {hw_q[c][SL_SRC_HI], hw_q[c][SL_SRC_LO]};
    assign dst_q[c]    = {hw_q[c][SL_DST_HI], hw_q[c][SL_DST_LO]};
    assign cnt_q[c]    = hw_q[c][SL_CNT];
    assign ctrl_q[c]   = hw_q[c][SL_CTRL];
    assign trig_vec[c] = wr_en && hit && (hit_ch == CH_W'(c)) &&
                         (hit_slot == SL_CTRL) && wr_be[1];
  end

  // high-byte command merges with the stored low byte
  assign trig_val = {wr_data[15:8], wr_be[0] ? wr_data[7:0] : ctrl_q[hit_ch][7:0]};

  p_single_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_vec));

  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit && hit_slot == SL_CTRL && wr_be == 2'b11)
    |=> ctrl_q[$past(hit_ch)] == $past(wr_data));
endmodule

// File: rtl/dma_arm_chan.sv
`timescale 1ns/1ps
module dma_arm_chan
  import dma_arm_pkg::*;
#(
  parameter int unsigned CH_IDX    = 0,
  parameter int unsigned FIFO_LO   = 1,
  parameter int unsigned FIFO_HI   = 2,
  parameter int unsigned LONG_CH   = 3,
  parameter int unsigned EEPROM_CH = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic [15:0] trig_val,
  input  logic [31:0] src_raw,
  input  logic [31:0] dst_raw,
  input  logic [15:0] cnt_raw,
  output desc_t       desc_q,
  output logic        armed_q,
  output logic        start_req,
  output logic        eeprom_hit
);
  localparam bit IS_FIFO = (CH_IDX >= FIFO_LO) && (CH_IDX <= FIFO_HI);
  localparam bit IS_LONG = (CH_IDX >= LONG_CH);
  localparam bit IS_EE   = (CH_IDX == EEPROM_CH);
  localparam int unsigned CW_RAW = IS_LONG ? 16 : SHORT_CNT_W;
  localparam logic [15:0] CNT_MASK = 16'((32'h1 << CW_RAW) - 1);

  timing_e                tm;
  logic                   arm_now;
  logic                   fifo_mode;
  logic [ADDR_KEEP_W-1:0] dst_m;
  logic [15:0]            cnt_m;
  desc_t                  nxt;

  assign tm        = timing_e'(trig_val[13:12]);
  assign arm_now   = trig && trig_val[15] && !armed_q;
  assign fifo_mode = IS_FIFO && (tm == TM_SPECIAL);
  assign dst_m     = dst_raw[ADDR_KEEP_W-1:0];
  assign cnt_m     = cnt_raw & CNT_MASK;

  always_comb begin
    nxt           = '0;
    nxt.src       = src_raw[ADDR_KEEP_W-1:0];
    nxt.dst       = dst_m;
    nxt.irq       = trig_val[14];
    nxt.repeat_en = trig_val[9];
    nxt.src_dir   = trig_val[8:7];
    nxt.timing    = tm;
    if (fifo_mode) begin
      nxt.cnt     = CNT_W'(FIFO_WORDS);
      nxt.wide    = 1'b1;
      nxt.dst_dir = DIR_FIXED;
      nxt.snd     = (dst_m == FIFO_B_ADDR) ? SND_B : SND_A;
    end else begin
      nxt.cnt     = (cnt_m == '0) ? (CNT_W'(1) << CW_RAW) : CNT_W'(cnt_m);
      nxt.wide    = trig_val[10];
      nxt.dst_dir = trig_val[6:5];
      nxt.snd     = SND_NONE;
    end
  end

  assign start_req  = arm_now && (tm == TM_IMM);
  assign eeprom_hit = arm_now && IS_EE && (dst_raw[31:24] == EE_DST_TAG) &&
                      (cnt_raw[4:0] == EE_CNT_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      desc_q  <= '0;
    end else if (trig) begin
      if (trig_val[15]) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          desc_q  <= nxt;
        end
      end else begin
        armed_q    <= 1'b0;
        desc_q.snd <= SND_NONE;
      end
    end
  end

  p_arm_by_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(trig && trig_val[15]));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (trig && trig_val[15] && armed_q) |=> $stable(desc_q) && armed_q);

  p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
    (trig && !trig_val[15]) |=> !armed_q && desc_q.snd == SND_NONE);

  p_count_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> desc_q.cnt != '0);

  p_fifo_shape_r7: assert property (@(posedge clk) disable iff (rst)
    (armed_q && desc_q.snd != SND_NONE)
    |-> desc_q.cnt == CNT_W'(FIFO_WORDS) && desc_q.wide && desc_q.dst_dir == DIR_FIXED);
endmodule

// File: rtl/dma_arm_prio.sv
`timescale 1ns/1ps
module dma_arm_prio #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/dma_arm_bank.sv
`timescale 1ns/1ps
module dma_arm_bank
  import dma_arm_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 176,
  parameter int unsigned STRIDE = 12,
  parameter int unsigned CH_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [15:0]                 wr_data,
  input  logic [1:0]                  wr_be,
  output logic [N_CH*16-1:0]          ctrl_word,
  output logic [N_CH-1:0]             armed,
  output logic [N_CH*ADDR_KEEP_W-1:0] desc_src,
  output logic [N_CH*ADDR_KEEP_W-1:0] desc_dst,
  output logic [N_CH*CNT_W-1:0]       desc_cnt,
  output logic [N_CH*2-1:0]           desc_timing,
  output logic [N_CH-1:0]             desc_irq,
  output logic [N_CH-1:0]             desc_wide,
  output logic [N_CH-1:0]             desc_repeat,
  output logic [N_CH*2-1:0]           desc_src_dir,
  output logic [N_CH*2-1:0]           desc_dst_dir,
  output logic [N_CH*2-1:0]           desc_snd,
  output logic                        start_pulse,
  output logic [CH_W-1:0]             start_chan,
  output logic                        eeprom_large
);
  logic [N_CH-1:0][31:0] src_q, dst_q;
  logic [N_CH-1:0][15:0] cnt_q, ctrl_q;
  logic [N_CH-1:0]       trig_vec, req_v, ee_v;
  logic [15:0]           trig_val;
  desc_t                 desc_all [N_CH];
  logic                  req_any;
  logic [CH_W-1:0]       req_idx;

  dma_arm_regs #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q),
    .trig_vec(trig_vec), .trig_val(trig_val)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_arm_chan #(.CH_IDX(c)) chan_i (
      .clk(clk), .rst(rst), .trig(trig_vec[c]), .trig_val(trig_val),
      .src_raw(src_q[c]), .dst_raw(dst_q[c]), .cnt_raw(cnt_q[c]),
      .desc_q(desc_all[c]), .armed_q(armed[c]),
      .start_req(req_v[c]), .eeprom_hit(ee_v[c])
    );
    assign ctrl_word[c*16 +: 16]                    = ctrl_q[c];
    assign desc_src[c*ADDR_KEEP_W +: ADDR_KEEP_W]   = desc_all[c].src;
    assign desc_dst[c*ADDR_KEEP_W +: ADDR_KEEP_W]   = desc_all[c].dst;
    assign desc_cnt[c*CNT_W +: CNT_W]               = desc_all[c].cnt;
    assign desc_timing[c*2 +: 2]                    = desc_all[c].timing;
    assign desc_irq[c]                              = desc_all[c].irq;
    assign desc_wide[c]                             = desc_all[c].wide;
    assign desc_repeat[c]                           = desc_all[c].repeat_en;
    assign desc_src_dir[c*2 +: 2]                   = desc_all[c].src_dir;
    assign desc_dst_dir[c*2 +: 2]                   = desc_all[c].dst_dir;
    assign desc_snd[c*2 +: 2]                       = desc_all[c].snd;
  end

  dma_arm_prio #(.N(N_CH), .W(CH_W)) prio_i (
    .req(req_v), .any(req_any), .idx(req_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pulse  <= 1'b0;
      start_chan   <= '0;
      eeprom_large <= 1'b0;
    end else begin
      start_pulse  <= req_any;
      start_chan   <= req_idx;
      eeprom_large <= eeprom_large | (|ee_v);
    end
  end

  p_start_valid_r9: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> armed[start_chan] && desc_timing[start_chan*2 +: 2] == 2'b00);

  p_eeprom_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    eeprom_large |=> eeprom_large);
endmodule

// File: tb/dma_arm_bank_tb_top.sv
`timescale 1ns/1ps
module dma_arm_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic [63:0]  ctrl_word;
  logic [3:0]   armed, desc_irq, desc_wide, desc_repeat;
  logic [111:0] desc_src, desc_dst;
  logic [67:0]  desc_cnt;
  logic [7:0]   desc_timing, desc_src_dir, desc_dst_dir, desc_snd;
  logic         start_pulse, eeprom_large;
  logic [1:0]   start_chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_arm_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .ctrl_word(ctrl_word), .armed(armed), .desc_src(desc_src),
    .desc_dst(desc_dst), .desc_cnt(desc_cnt), .desc_timing(desc_timing),
    .desc_irq(desc_irq), .desc_wide(desc_wide), .desc_repeat(desc_repeat),
    .desc_src_dir(desc_src_dir), .desc_dst_dir(desc_dst_dir), .desc_snd(desc_snd),
    .start_pulse(start_pulse), .start_chan(start_chan), .eeprom_large(eeprom_large)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] v);
    wr(a, v[15:0], 2'b11);
    wr(a + 8'd2, v[31:16], 2'b11);
  endtask

  function automatic logic [7:0] base_of(input int c);
    return 8'hB0 + 8'(12 * c);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] cnt_set [4];
    logic [31:0] dst_set [2];
    cnt_set[0] = 16'h0000; cnt_set[1] = 16'h0011;
    cnt_set[2] = 16'h3FFF; cnt_set[3] = 16'hC005;
    dst_set[0] = 32'h040000A4; dst_set[1] = 32'hF9001234;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ctrl words", ctrl_word[31:0] | ctrl_word[63:32], 32'h0);
    chk("R1", "armed", 32'(armed), 32'h0);
    chk("R1", "count", desc_cnt[31:0], 32'h0);
    chk("R1", "pulse", 32'(start_pulse), 32'h0);
    chk("R1", "eeprom", 32'(eeprom_large), 32'h0);

    // main sweep: channel x timing x count x destination
    for (int c = 0; c < 4; c++) begin
      for (int tm = 0; tm < 4; tm++) begin
        for (int ci = 0; ci < 4; ci++) begin
          for (int di = 0; di < 2; di++) begin
            logic [31:0] srcv, e_cnt;
            logic [15:0] ctl;
            logic fifo;
            logic [1:0] e_snd;
            srcv = 32'hA000_0000 | (32'(c) << 12) | (32'(tm) << 8) | (32'(ci) << 4) | 32'(di);
            wr32(base_of(c), srcv);
            wr32(base_of(c) + 8'd4, dst_set[di]);
            wr(base_of(c) + 8'd8, cnt_set[ci], 2'b11);
            ctl = 16'h8000 | (16'(tm) << 12) | (16'(ci & 1) << 14) | (16'(di) << 10) |
                  (16'((ci >> 1) & 1) << 9) | 16'h0080 | 16'h0060;
            wr(base_of(c) + 8'd10, ctl, 2'b11);
            fifo = ((c == 1) || (c == 2)) && (tm == 3);
            if (fifo) e_cnt = 32'd4;
            else if (c < 3) begin
              e_cnt = 32'(cnt_set[ci]) & 32'h3FFF;
              if (e_cnt == 0) e_cnt = 32'h4000;
            end else begin
              e_cnt = 32'(cnt_set[ci]);
              if (e_cnt == 0) e_cnt = 32'h10000;
            end
            e_snd = !fifo ? 2'b00 : (di == 0) ? 2'b10 : 2'b01;
            chk("R3", "armed vector", 32'(armed), 32'(1) << c);
            chk("R3", "source", 32'(desc_src[c*28 +: 28]), srcv & 32'h0FFFFFFF);
            chk("R3", "destination", 32'(desc_dst[c*28 +: 28]), dst_set[di] & 32'h0FFFFFFF);
            chk("R3", "irq/repeat/srcdir/timing",
                {24'h0, desc_irq[c], desc_repeat[c], desc_src_dir[c*2 +: 2], desc_timing[c*2 +: 2], 2'b00},
                {24'h0, 1'(ci & 1), 1'((ci >> 1) & 1), 2'b01, 2'(tm), 2'b00});
            chk("R2", "stored control", 32'(ctrl_word[c*16 +: 16]), 32'(ctl));
            chk("R6", "count", 32'(desc_cnt[c*17 +: 17]), e_cnt);
            chk("R7", "wide", 32'(desc_wide[c]), fifo ? 32'd1 : 32'(di));
            chk("R7", "dst dir", 32'(desc_dst_dir[c*2 +: 2]), fifo ? 32'd2 : 32'd3);
            chk("R7", "sound select", 32'(desc_snd[c*2 +: 2]), 32'(e_snd));
            chk("R9", "pulse", 32'(start_pulse), (tm == 0) ? 32'd1 : 32'd0);
            if (tm == 0) chk("R9", "pulse channel", 32'(start_chan), 32'(c));
            @(negedge clk);
            chk("R9", "pulse width", 32'(start_pulse), 32'd0);
            wr(base_of(c) + 8'd10, 16'h0000, 2'b11);
            chk("R5", "disarmed", 32'(armed), 32'h0);
            chk("R5", "sound cleared", 32'(desc_snd[c*2 +: 2]), 32'h0);
            chk("R5", "control stored", 32'(ctrl_word[c*16 +: 16]), 32'h0);
          end
        end
      end
    end
    chk("R8", "flag idle after sweep", 32'(eeprom_large), 32'd0);

    // R2 byte lanes and R10 low-byte control write on channel 2
    wr32(base_of(2), 32'h0567_1234);
    wr(base_of(2) + 8'd2, 16'h00FF, 2'b01);
    wr(base_of(2) + 8'd8, 16'h0000, 2'b11);
    wr(base_of(2) + 8'd10, 16'h8065, 2'b01);
    chk("R10", "low byte stored", 32'(ctrl_word[47:32]), 32'h0065);
    chk("R10", "not armed", 32'(armed), 32'h0);
    chk("R10", "no pulse", 32'(start_pulse), 32'h0);
    wr(base_of(2) + 8'd10, 16'h80AA, 2'b10);
    chk("R2", "merged control", 32'(ctrl_word[47:32]), 32'h8065);
    chk("R2", "armed by high byte", 32'(armed), 32'h4);
    chk("R2", "byte-lane source", 32'(desc_src[2*28 +: 28]), 32'h05FF_1234);
    chk("R2", "merged dst dir", 32'(desc_dst_dir[5:4]), 32'd3);
    chk("R2", "merged src dir", 32'(desc_src_dir[5:4]), 32'd0);
    chk("R6", "zero count ch2", 32'(desc_cnt[2*17 +: 17]), 32'h4000);
    chk("R9", "pulse ch2", {start_pulse, start_chan}, 32'b110);
    wr(base_of(2) + 8'd10, 16'h0000, 2'b11);

    // R4 enable write to a busy channel
    wr32(base_of(0), 32'h1111_1111);
    wr(base_of(0) + 8'd10, 16'hB000, 2'b11);
    chk("R4", "armed special", 32'(armed), 32'h1);
    chk("R9", "no pulse for special", 32'(start_pulse), 32'h0);
    wr(base_of(0), 16'h2222, 2'b11);
    wr(base_of(0) + 8'd10, 16'h8000, 2'b11);
    chk("R4", "control updated", 32'(ctrl_word[15:0]), 32'h8000);
    chk("R4", "source held", 32'(desc_src[27:0]), 32'h0111_1111);
    chk("R4", "timing held", 32'(desc_timing[1:0]), 32'd3);
    chk("R4", "no pulse", 32'(start_pulse), 32'h0);
    chk("R4", "still armed", 32'(armed), 32'h1);
    wr(base_of(0) + 8'd10, 16'h0000, 2'b11);

    // R8 EEPROM detection: channel 2 must not set it, channel 3 must
    wr32(base_of(2) + 8'd4, 32'h0D00_0000);
    wr(base_of(2) + 8'd8, 16'h0031, 2'b11);
    wr(base_of(2) + 8'd10, 16'h9000, 2'b11);
    chk("R8", "not set by ch2", 32'(eeprom_large), 32'd0);
    wr(base_of(2) + 8'd10, 16'h0000, 2'b11);
    wr32(base_of(3) + 8'd4, 32'h0D00_0000);
    wr(base_of(3) + 8'd8, 16'h0031, 2'b11);
    wr(base_of(3) + 8'd10, 16'h9000, 2'b11);
    chk("R8", "set by ch3", 32'(eeprom_large), 32'd1);
    chk("R6", "ch3 full count", 32'(desc_cnt[3*17 +: 17]), 32'h31);
    wr(base_of(3) + 8'd10, 16'h0000, 2'b11);
    chk("R8", "sticky after disarm", 32'(eeprom_large), 32'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule